// File: doc/BRIEF.md
# Parallel Video Transmit Sync Generator

This block produces the internal timing for a parallel video transmit port running with two hardware syncs. A 16-bit column counter and a 16-bit row counter walk the raster. From them the block derives a line sync, a frame sync, a data-enable strobe and a pixel-request strobe. The pixel-request strobe tells the upstream data path which cycles must carry a sample. A one-cycle frame-done pulse marks the end of every frame.

The data-enable output runs in one of two ways. In window mode it follows the active data region exactly: it is clipped at the end of the line and at the end of the frame. In pulse mode it starts at the first active column of each active row and then counts out the programmed active width, even when that width runs past the end of the line. Window mode applies only when blanking generation is on and the sample width is 8, 10 or 16 bits. Data-enable is always active high. The output launch edge is modelled as a registered select: the late setting delays the port pins by one clock.

Top module: `vid_sync_gen`

## Requirements
- R1: `hsync_o` is at its active level for `hs_width` cycles at column 0..`hs_width`-1 of every line. The active level is high when `sync_pol`=0 and low when `sync_pol`=1. While disabled it rests at the inactive level.
- R2: `vsync_o` is at its active level during rows 0..`vs_width`-1 of every frame, with the same polarity rule as R1.
- R3: While `enable` is low, both counters are held at zero and `den_o` is low. Edge 0 is the first rising edge that sees `enable` high. Raster position n (n = row*`h_period`+column) appears on the outputs in the cycle that starts at edge n, so the first `den_o` high falls at cycle `v_delay`*`h_period`+`h_delay`.
- R4: The `dlen_code` values are 0=8, 1=10, 2=12, 3=14, 4=16, 5=18, 6=20 and 7=24 bits. Window mode is selected only when `blank_en`=1 and the code is 0, 1 or 4. Every other combination selects pulse mode.
- R5: In window mode, `den_o` is high exactly when the column lies in [`h_delay`, `h_delay`+`h_active`) and the row lies in [`v_delay`, `v_delay`+`v_active`). Both ranges are clipped by the line and frame lengths.
- R6: In pulse mode, `den_o` rises at column `h_delay` of every row in the vertical active range and stays high for exactly `h_active` cycles, continuing into the next line if needed.
- R7: `den_o` is active high in both modes, and `sync_pol` has no effect on it.
- R8: With `late_launch`=1, `hsync_o`, `vsync_o` and `den_o` appear one cycle later than with `late_launch`=0. `pix_req_o` and `frame_done_o` are not delayed.
- R9: `pix_req_o` is high for the window-mode data region of R5 in both modes, with no launch delay, so it leads `den_o` by the launch delay.
- R10: `frame_done_o` is high for one cycle per frame, in the cycle that starts at the edge of the frame's last position (cycle `h_period`*`v_period`-1 of each frame).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the raster; low holds counters at zero |
| h_delay | input | 16 | Columns before the active region of a line |
| h_active | input | 16 | Active samples per line |
| h_period | input | 16 | Clocks per line |
| hs_width | input | 16 | Line-sync width in clocks |
| v_delay | input | 16 | Rows before the active region of a frame |
| v_active | input | 16 | Active rows per frame |
| v_period | input | 16 | Rows per frame |
| vs_width | input | 16 | Frame-sync width in rows |
| blank_en | input | 1 | Blanking generation on |
| dlen_code | input | 3 | Sample width code (R4) |
| late_launch | input | 1 | Launch port pins one clock later |
| sync_pol | input | 1 | 1 = syncs active low |
| hsync_o | output | 1 | Line sync, first sync pin |
| vsync_o | output | 1 | Frame sync, second sync pin |
| den_o | output | 1 | Data enable, third sync pin |
| pix_req_o | output | 1 | Upstream sample request |
| frame_done_o | output | 1 | End-of-frame pulse |

## Verification
The main corner case is a line where `h_delay`+`h_active` exceeds `h_period`. Window mode must clip there and pulse mode must spill into the next line. A design that treats the two modes the same, or decodes the wrong sample-width codes, gives the wrong data-enable count per frame. Active rows that run past the frame end must be clipped; a design that wraps them produces extra pulses. The late launch must shift the port pins by exactly one cycle while the pixel request stays in place, and a design that shifts everything or nothing breaks the lead of one over the other. With inverted sync polarity, data-enable must keep the same count and level, and the syncs must rest at high while disabled.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int CNT_W  = 16;
  localparam int DLEN_W = 3;

  typedef enum logic [DLEN_W-1:0] {
    DL8  = 3'd0, DL10 = 3'd1, DL12 = 3'd2, DL14 = 3'd3,
    DL16 = 3'd4, DL18 = 3'd5, DL20 = 3'd6, DL24 = 3'd7
  } dlen_e;

  typedef enum logic {
    DEN_WINDOW = 1'b0,
    DEN_PULSE  = 1'b1
  } den_mode_e;

  typedef struct packed {
    logic hsync;
    logic vsync;
    logic den;
  } port_sig_t;

  function automatic den_mode_e pick_den_mode(input logic blank,
                                              input logic [DLEN_W-1:0] code);
    den_mode_e m;
    m = DEN_PULSE;
    if (blank && (code == DL8 || code == DL10 || code == DL16)) m = DEN_WINDOW;
    return m;
  endfunction
endpackage

// File: rtl/vsg_raster.sv
module vsg_raster #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] h_period_i,
  input  logic [CW-1:0] v_period_i,
  output logic [CW-1:0] h_cnt_o,
  output logic [CW-1:0] v_cnt_o,
  output logic          frame_end_o
);
  logic [CW-1:0] h_q, h_d, v_q, v_d;
  logic          line_last, frame_last;

  always_comb begin
    line_last  = (h_q >= (h_period_i - 1'b1));
    frame_last = line_last && (v_q >= (v_period_i - 1'b1));
    h_d = h_q;
    v_d = v_q;
    if (!run_i) begin
      h_d = '0;
      v_d = '0;
    end else if (line_last) begin
      h_d = '0;
      v_d = frame_last ? '0 : v_q + 1'b1;
    end else begin
      h_d = h_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign h_cnt_o     = h_q;
  assign v_cnt_o     = v_q;
  assign frame_end_o = run_i && frame_last;

  // R3
  h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && h_q != '0) |-> (h_q == $past(h_q) + 1'b1));
endmodule

// File: rtl/vsg_window.sv
module vsg_window
  import vsg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  den_mode_e     mode_i,
  input  logic [CW-1:0] h_cnt_i,
  input  logic [CW-1:0] v_cnt_i,
  input  logic [CW-1:0] h_delay_i,
  input  logic [CW-1:0] h_active_i,
  input  logic [CW-1:0] hs_width_i,
  input  logic [CW-1:0] v_delay_i,
  input  logic [CW-1:0] v_active_i,
  input  logic [CW-1:0] vs_width_i,
  output port_sig_t     raw_o,
  output logic          pix_o
);
  localparam int EW = CW + 1;

  logic [EW-1:0] h_end, v_end;
  logic          h_in, v_in, start_hit, pulse;
  logic [CW-1:0] left_q, left_d;

  always_comb begin
    h_end = {1'b0, h_delay_i} + {1'b0, h_active_i};
    v_end = {1'b0, v_delay_i} + {1'b0, v_active_i};
    h_in  = (h_cnt_i >= h_delay_i) && ({1'b0, h_cnt_i} < h_end);
    v_in  = (v_cnt_i >= v_delay_i) && ({1'b0, v_cnt_i} < v_end);
    start_hit = run_i && v_in && (h_cnt_i == h_delay_i) && (h_active_i != '0);
  end

  // pulse-mode length counter: loads at the line's first active column
  always_comb begin
    left_d = left_q;
    pulse  = 1'b0;
    if (!run_i) begin
      left_d = '0;
    end else if (start_hit) begin
      left_d = h_active_i - 1'b1;
      pulse  = 1'b1;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
      pulse  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  always_comb begin
    pix_o       = run_i && h_in && v_in;
    raw_o.hsync = run_i && (h_cnt_i < hs_width_i);
    raw_o.vsync = run_i && (v_cnt_i < vs_width_i);
    raw_o.den   = (mode_i == DEN_WINDOW) ? pix_o : pulse;
  end

  // R6
  den_len_chk: assert property (@(posedge clk) disable iff (!rst_n || !run_i)
    (left_q == '0) || (left_q < h_active_i));
endmodule

// File: rtl/vsg_launch.sv
module vsg_launch
  import vsg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_i,
  input  logic      late_i,
  input  logic      spol_i,
  input  port_sig_t raw_i,
  input  logic      pix_i,
  input  logic      fend_i,
  output port_sig_t port_o,
  output logic      pix_o,
  output logic      fdone_o
);
  port_sig_t s1_q, s1_d, s2_q;
  logic      late_q, pix_q, fd_q;

  always_comb begin
    s1_d.hsync = raw_i.hsync ^ spol_i;
    s1_d.vsync = raw_i.vsync ^ spol_i;
    s1_d.den   = raw_i.den;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      late_q <= 1'b0;
      pix_q  <= 1'b0;
      fd_q   <= 1'b0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s1_q;
      late_q <= late_i;
      pix_q  <= pix_i;
      fd_q   <= fend_i;
    end
  end

  assign port_o  = late_q ? s2_q : s1_q;
  assign pix_o   = pix_q;
  assign fdone_o = fd_q;

  // R3
  den_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_i) |-> !s1_q.den);

  // R1
  hsync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_i) |-> (s1_q.hsync == $past(spol_i)));
endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen
  import vsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CNT_W-1:0]  h_delay,
  input  logic [CNT_W-1:0]  h_active,
  input  logic [CNT_W-1:0]  h_period,
  input  logic [CNT_W-1:0]  hs_width,
  input  logic [CNT_W-1:0]  v_delay,
  input  logic [CNT_W-1:0]  v_active,
  input  logic [CNT_W-1:0]  v_period,
  input  logic [CNT_W-1:0]  vs_width,
  input  logic              blank_en,
  input  logic [DLEN_W-1:0] dlen_code,
  input  logic              late_launch,
  input  logic              sync_pol,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              den_o,
  output logic              pix_req_o,
  output logic              frame_done_o
);
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic             fend, pix_raw;
  den_mode_e        mode;
  port_sig_t        raw, port;

  assign mode = pick_den_mode(blank_en, dlen_code);

  vsg_raster #(.CW(CNT_W)) u_raster (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (enable),
    .h_period_i (h_period),
    .v_period_i (v_period),
    .h_cnt_o    (h_cnt),
    .v_cnt_o    (v_cnt),
    .frame_end_o(fend)
  );

  vsg_window #(.CW(CNT_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (enable),
    .mode_i     (mode),
    .h_cnt_i    (h_cnt),
    .v_cnt_i    (v_cnt),
    .h_delay_i  (h_delay),
    .h_active_i (h_active),
    .hs_width_i (hs_width),
    .v_delay_i  (v_delay),
    .v_active_i (v_active),
    .vs_width_i (vs_width),
    .raw_o      (raw),
    .pix_o      (pix_raw)
  );

  vsg_launch u_launch (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (enable),
    .late_i  (late_launch),
    .spol_i  (sync_pol),
    .raw_i   (raw),
    .pix_i   (pix_raw),
    .fend_i  (fend),
    .port_o  (port),
    .pix_o   (pix_req_o),
    .fdone_o (frame_done_o)
  );

  assign hsync_o = port.hsync;
  assign vsync_o = port.vsync;
  assign den_o   = port.den;

  // R10
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (h_cnt == '0 && v_cnt == '0));
endmodule

// File: tb/tb_vid_sync_gen.sv
`timescale 1ns/1ps
module tb_vid_sync_gen;
  logic        clk, rst_n, enable;
  logic [15:0] h_delay, h_active, h_period, hs_width;
  logic [15:0] v_delay, v_active, v_period, vs_width;
  logic        blank_en, late_launch, sync_pol;
  logic [2:0]  dlen_code;
  logic        hsync_o, vsync_o, den_o, pix_req_o, frame_done_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  vid_sync_gen dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    int hp, hd, ha, vp, vd, va;
    logic b; logic [2:0] dl; logic late; logic spol;
    int cnt; int first; int pcnt;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{12, 3, 5, 5, 1, 3, 1'b1, 3'd0, 1'b0, 1'b0, 15, 15, 15},
    '{12, 3, 5, 5, 1, 3, 1'b1, 3'd0, 1'b1, 1'b1, 15, 16, 15},
    '{10, 6, 6, 4, 1, 2, 1'b1, 3'd4, 1'b0, 1'b0,  8, 16,  8},
    '{10, 6, 6, 4, 1, 2, 1'b0, 3'd4, 1'b0, 1'b0, 12, 16,  8},
    '{10, 6, 6, 4, 1, 2, 1'b1, 3'd2, 1'b1, 1'b1, 12, 17,  8},
    '{ 8, 0, 3, 4, 2, 5, 1'b1, 3'd1, 1'b0, 1'b0,  6, 16,  6},
    '{ 8, 0, 3, 4, 2, 5, 1'b1, 3'd7, 1'b1, 1'b0,  6, 17,  6}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input vec_t v);
    h_period = 16'(v.hp); h_delay = 16'(v.hd); h_active = 16'(v.ha);
    v_period = 16'(v.vp); v_delay = 16'(v.vd); v_active = 16'(v.va);
    blank_en = v.b; dlen_code = v.dl; late_launch = v.late; sync_pol = v.spol;
  endtask

  task automatic run_vec(input vec_t v);
    int f, fden, fpix, dc, pc, hc, vc, fdc, lt;
    logic fd_at;
    bit win;
    string mtag;
    win  = v.b && (v.dl == 3'd0 || v.dl == 3'd1 || v.dl == 3'd4);
    mtag = win ? "R4 R5" : "R4 R6";
    lt   = v.late ? 1 : 0;
    @(negedge clk);
    enable = 1'b0;
    load_cfg(v);
    repeat (3) @(negedge clk);
    enable = 1'b1;
    f = v.hp * v.vp;
    fden = -1; fpix = -1; dc = 0; pc = 0; hc = 0; vc = 0; fdc = 0; fd_at = 1'b0;
    for (int j = 0; j < 2 * f + 3; j++) begin
      @(negedge clk);
      if (den_o && fden < 0) fden = j;
      if (pix_req_o && fpix < 0) fpix = j;
      if (j >= f + lt && j < 2 * f + lt) begin
        if (den_o) dc++;
        if (hsync_o != v.spol) hc++;
        if (vsync_o != v.spol) vc++;
      end
      if (j >= f && j < 2 * f) begin
        if (pix_req_o) pc++;
        if (frame_done_o) fdc++;
      end
      if (j == f - 1) fd_at = frame_done_o;
    end
    enable = 1'b0;
    check(dc == v.cnt, v.spol ? {mtag, " R7 den count"} : {mtag, " den count"}, dc, v.cnt);
    check(fden == v.first, "R3 R8 first den", fden, v.first);
    check(fden - fpix == lt, "R8 R9 pix lead", fden - fpix, lt);
    check(pc == v.pcnt, "R9 pix count", pc, v.pcnt);
    check(hc == 2 * v.vp, "R1 hsync count", hc, 2 * v.vp);
    check(vc == v.hp, "R2 vsync count", vc, v.hp);
    check(fdc == 1, "R10 frame_done count", fdc, 1);
    check(fd_at == 1'b1, "R10 frame_done position", int'(fd_at), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int fden;
    rst_n = 1'b0; enable = 1'b0;
    hs_width = 16'd2; vs_width = 16'd1;
    load_cfg(VEC[0]);
    repeat (3) @(negedge clk);
    // reset state (R3, R1, R2, R9, R10)
    check(den_o == 1'b0, "R3 reset den", int'(den_o), 0);
    check(hsync_o == 1'b0 && vsync_o == 1'b0, "R1 R2 reset syncs", int'({hsync_o, vsync_o}), 0);
    check(pix_req_o == 1'b0, "R9 reset pix", int'(pix_req_o), 0);
    check(frame_done_o == 1'b0, "R10 reset frame_done", int'(frame_done_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // idle levels with inverted sync polarity (R1, R2, R7)
    @(negedge clk);
    load_cfg(VEC[1]);
    enable = 1'b0;
    repeat (4) @(negedge clk);
    check(hsync_o == 1'b1, "R1 idle hsync inverted", int'(hsync_o), 1);
    check(vsync_o == 1'b1, "R2 idle vsync inverted", int'(vsync_o), 1);
    check(den_o == 1'b0, "R7 idle den low", int'(den_o), 0);

    // disable mid-frame, then restart from position zero (R3)
    load_cfg(VEC[0]);
    enable = 1'b1;
    repeat (20) @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check(den_o == 1'b0, "R3 den after disable", int'(den_o), 0);
    enable = 1'b1;
    fden = -1;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (den_o && fden < 0) fden = j;
    end
    check(fden == 15, "R3 restart first den", fden, 15);
    enable = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule